// File: doc/BRIEF.md
# Sixteen-Bit Timer with Compare and Capture

A 16-bit timer/counter that advances on a tick-enable input and drives two waveform pins from two independent compare channels. It runs in one of three waveform modes: a free-running counter that wraps at its maximum, a clear-on-match mode whose period is set by channel A's compare value, and a phase-correct PWM mode that counts up to a programmable top and back down to zero. In PWM mode the compare values are double-buffered, so a new value only takes effect at the turning point of the cycle.

A capture channel watches an external pin through a synchronizer and an optional noise canceller. It copies the counter into a capture register on the selected edge. Four sticky flags report overflow, compare match A, compare match B and capture. Software sets the block up through a small write-only port: a control word, two compare values, the PWM top, and a write-one-to-clear flag register. Strobe bits in the control word force a compare action at once.

Top module: `tmr16_core`

## Requirements
- R1: After reset, wave_a, wave_b, cap_value and irq_flags are all zero, the control word is zero (free-running mode), and the PWM top is all ones.
- R2: The counter advances only on cycles where tick is high. In free-running mode (control bits [1:0] = 0) it steps up by one and wraps from all ones to zero. The overflow flag, irq_flags bit 0, sets on the edge of that wrap.
- R3: In clear-on-match mode (control bits [1:0] = 1), a tick taken while the counter equals compare A (address 1) returns the counter to zero. The period is compare A plus one ticks. On a tick where the counter equals compare A or compare B (address 2), irq_flags bit 1 or bit 2 sets.
- R4: Outside PWM mode, a match on channel A or B applies that channel's 2-bit action field (A in control bits [3:2], B in bits [5:4]) to its pin: 0 holds, 1 toggles, 2 drives low, 3 drives high.
- R5: In phase-correct mode (control bit 1 set), the counter runs 0, 1, …, top, top−1, …, 0, 1, … with top written at address 3. The overflow flag sets on every tick taken while the counter is at zero.
- R6: In phase-correct mode, action 2 drives the pin low on a match while counting up and high on a match while counting down. Action 3 does the reverse. Actions 0 and 1 leave the pin unchanged. For top T and compare C, action 2 gives a pin that is low for 2(T−C) ticks and high for 2C ticks.
- R7: In phase-correct mode a compare write goes into a buffer, and the buffer moves to the active compare on the tick taken at top. In the other modes a compare write takes effect on the next cycle.
- R8: A control write with bit 8 (channel A) or bit 9 (channel B) set applies the action field carried by that same write to the pin at once. This does not set a match flag. When the written mode is phase-correct the strobe is ignored.
- R9: Control bit 6 selects the capture edge on cap_in (1 = rising, 0 = falling). On the selected edge, cap_value takes the counter value and irq_flags bit 3 sets. The other edge changes nothing.
- R10: With control bit 7 set, a change on cap_in is accepted only after four consecutive equal synchronized samples. A pulse two cycles wide is therefore rejected.
- R11: Flags stay set until written with a one at address 4, bits [3:0]. If a flag sets in the same cycle as its clear, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 control, 1 compare A, 2 compare B, 3 top, 4 flag clear |
| wr_data | input | 16 | Register write data |
| cap_in | input | 1 | Asynchronous capture pin |
| wave_a | output | 1 | Channel A waveform pin |
| wave_b | output | 1 | Channel B waveform pin |
| cap_value | output | 16 | Last captured counter value |
| irq_flags | output | 4 | Sticky flags: [0] overflow, [1] match A, [2] match B, [3] capture |

## Verification
The case hardest to reach from the ports is a compare write that lands mid-cycle in phase-correct mode. An unbuffered design and a buffered one differ in only one pulse width, and only on the half-cycle after the write. The stimulus waits for a rising pin edge, which marks the down-count match, and writes the new compare on the next cycle. It then times the following low phase. That phase lasts five ticks when the old value holds until top and six when the new value takes effect at once. Capture values are made exact by stopping tick, so the counter is frozen at a known count before the pin moves.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
   typedef enum logic [1:0] {
      MODE_FREE  = 2'd0,
      MODE_CTC   = 2'd1,
      MODE_PC    = 2'd2,
      MODE_PC2   = 2'd3
   } tmr_mode_e;

   typedef enum logic [1:0] {
      ACT_HOLD   = 2'd0,
      ACT_TOGGLE = 2'd1,
      ACT_LOW    = 2'd2,
      ACT_HIGH   = 2'd3
   } tmr_act_e;

   localparam int ADR_CTRL  = 0;
   localparam int ADR_CMP0  = 1;
   localparam int ADR_TOP   = 3;
   localparam int ADR_FLAGS = 4;

   localparam int NUM_CH    = 2;
   localparam int NUM_FLAGS = 4;

   localparam int CB_ACT0   = 2;
   localparam int CB_EDGE   = 6;
   localparam int CB_NC     = 7;
   localparam int CB_FORCE0 = 8;
endpackage

// File: rtl/tmr16_counter.sv
module tmr16_counter
   import tmr16_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  tmr_mode_e    mode,
   input  logic [W-1:0] cmp_a,
   input  logic [W-1:0] top_val,
   output logic [W-1:0] cnt,
   output logic         up,
   output logic         top_ev,
   output logic         ovf_ev
);
   localparam logic [W-1:0] ONE  = W'(1);
   localparam logic [W-1:0] ZERO = '0;
   localparam logic [W-1:0] MAX  = '1;

   logic         pc;
   logic [W-1:0] cnt_nx;
   logic         up_nx;

   assign pc = mode[1];

   always_comb begin
      cnt_nx = cnt;
      up_nx  = up;
      if (pc) begin
         if (up) begin
            if (cnt >= top_val) begin
               up_nx  = 1'b0;
               cnt_nx = (top_val == ZERO) ? ZERO : top_val - ONE;
            end else begin
               cnt_nx = cnt + ONE;
            end
         end else begin
            if (cnt == ZERO) begin
               up_nx  = 1'b1;
               cnt_nx = (top_val == ZERO) ? ZERO : ONE;
            end else begin
               cnt_nx = cnt - ONE;
            end
         end
      end else if (mode == MODE_CTC) begin
         up_nx  = 1'b1;
         cnt_nx = (cnt == cmp_a) ? ZERO : cnt + ONE;
      end else begin
         up_nx  = 1'b1;
         cnt_nx = cnt + ONE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= ZERO;
         up  <= 1'b1;
      end else if (tick) begin
         cnt <= cnt_nx;
         up  <= up_nx;
      end
   end

   assign top_ev = tick && pc && up && (cnt >= top_val);
   assign ovf_ev = tick && (pc ? (cnt == ZERO) : (cnt == MAX));
endmodule

// File: rtl/tmr16_cmp_ch.sv
module tmr16_cmp_ch
   import tmr16_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         pc,
   input  logic         up,
   input  logic [W-1:0] cnt,
   input  logic         wr_cmp,
   input  logic [W-1:0] wr_val,
   input  logic         load_ev,
   input  tmr_act_e     act,
   input  logic         force_stb,
   input  tmr_act_e     force_act,
   output logic [W-1:0] cmp_now,
   output logic         match_ev,
   output logic         wave
);
   logic [W-1:0] cmp_buf;
   logic         wave_nx;

   function automatic logic apply_act(input tmr_act_e a, input logic cur);
      case (a)
         ACT_TOGGLE: apply_act = ~cur;
         ACT_LOW:    apply_act = 1'b0;
         ACT_HIGH:   apply_act = 1'b1;
         default:    apply_act = cur;
      endcase
   endfunction

   assign match_ev = tick && (cnt == cmp_now);

   always_comb begin
      wave_nx = wave;
      if (force_stb) begin
         wave_nx = apply_act(force_act, wave);
      end else if (match_ev) begin
         if (pc) begin
            if (act == ACT_LOW)       wave_nx = ~up;
            else if (act == ACT_HIGH) wave_nx = up;
         end else begin
            wave_nx = apply_act(act, wave);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_buf <= '0;
         cmp_now <= '0;
         wave    <= 1'b0;
      end else begin
         wave <= wave_nx;
         if (wr_cmp) cmp_buf <= wr_val;
         if (wr_cmp && !pc)      cmp_now <= wr_val;
         else if (pc && load_ev) cmp_now <= wr_cmp ? wr_val : cmp_buf;
      end
   end
endmodule

// File: rtl/tmr16_capture.sv
module tmr16_capture #(
   parameter int W        = 16,
   parameter int SYNC     = 2,
   parameter int NC_DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pin,
   input  logic         rise_sel,
   input  logic         nc_en,
   input  logic [W-1:0] cnt,
   output logic [W-1:0] cap_val,
   output logic         cap_ev
);
   logic [SYNC-1:0]     sync_q;
   logic [NC_DEPTH-1:0] hist_q;
   logic                filt_q;
   logic                filt_nx;
   logic                pin_s;

   assign pin_s = sync_q[SYNC-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         hist_q <= '0;
      end else begin
         sync_q <= {sync_q[SYNC-2:0], pin};
         hist_q <= {hist_q[NC_DEPTH-2:0], pin_s};
      end
   end

   always_comb begin
      if (!nc_en)           filt_nx = pin_s;
      else if (&hist_q)     filt_nx = 1'b1;
      else if (~|hist_q)    filt_nx = 1'b0;
      else                  filt_nx = filt_q;
   end

   assign cap_ev = (filt_nx != filt_q) && (filt_nx == rise_sel);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         filt_q  <= 1'b0;
         cap_val <= '0;
      end else begin
         filt_q <= filt_nx;
         if (cap_ev) cap_val <= cnt;
      end
   end
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
   import tmr16_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int ADDR_W   = 3,
   parameter int SYNC     = 2,
   parameter int NC_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              cap_in,
   output logic              wave_a,
   output logic              wave_b,
   output logic [CNT_W-1:0]  cap_value,
   output logic [3:0]        irq_flags
);
   if (CNT_W < 10) begin : g_bad_width
      $error("tmr16_core: CNT_W must hold the control word (>= 10)");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("tmr16_core: ADDR_W must reach address 4 (>= 3)");
   end
   if (SYNC < 2) begin : g_bad_sync
      $error("tmr16_core: SYNC needs at least two stages");
   end
   if (NC_DEPTH < 2) begin : g_bad_nc
      $error("tmr16_core: NC_DEPTH must be at least 2");
   end

   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(ADR_CTRL);
   localparam logic [ADDR_W-1:0] A_TOP   = ADDR_W'(ADR_TOP);
   localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(ADR_FLAGS);

   tmr_mode_e                  mode_q;
   tmr_act_e [NUM_CH-1:0]      act_q;
   logic                       rise_q;
   logic                       nc_q;
   logic [CNT_W-1:0]           top_q;
   logic [NUM_FLAGS-1:0]       flags_q;

   logic                       wr_ctrl;
   logic                       wr_flags;
   logic                       wr_pc;
   logic [CNT_W-1:0]           cnt_q;
   logic                       cnt_up;
   logic                       top_ev;
   logic                       ovf_ev;
   logic                       cap_ev;
   logic [NUM_CH-1:0]          m_ev;
   logic [NUM_CH-1:0]          waves;
   logic [NUM_CH-1:0][CNT_W-1:0] cmp_now;
   logic [NUM_FLAGS-1:0]       set_v;
   logic [NUM_FLAGS-1:0]       clr_v;

   assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
   assign wr_flags = wr_en && (wr_addr == A_FLAGS);
   assign wr_pc    = wr_data[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MODE_FREE;
         act_q  <= '{default: ACT_HOLD};
         rise_q <= 1'b0;
         nc_q   <= 1'b0;
         top_q  <= '1;
      end else if (wr_en) begin
         if (wr_ctrl) begin
            mode_q <= tmr_mode_e'(wr_data[1:0]);
            for (int k = 0; k < NUM_CH; k++)
               act_q[k] <= tmr_act_e'(wr_data[CB_ACT0 + 2*k +: 2]);
            rise_q <= wr_data[CB_EDGE];
            nc_q   <= wr_data[CB_NC];
         end
         if (wr_addr == A_TOP) top_q <= wr_data;
      end
   end

   tmr16_counter #(.W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .mode    (mode_q),
      .cmp_a   (cmp_now[0]),
      .top_val (top_q),
      .cnt     (cnt_q),
      .up      (cnt_up),
      .top_ev  (top_ev),
      .ovf_ev  (ovf_ev)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic wr_cmp;
      logic frc;
      assign wr_cmp = wr_en && (wr_addr == ADDR_W'(ADR_CMP0 + i));
      assign frc    = wr_ctrl && wr_data[CB_FORCE0 + i] && !wr_pc;

      tmr16_cmp_ch #(.W(CNT_W)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick      (tick),
         .pc        (mode_q[1]),
         .up        (cnt_up),
         .cnt       (cnt_q),
         .wr_cmp    (wr_cmp),
         .wr_val    (wr_data),
         .load_ev   (top_ev),
         .act       (act_q[i]),
         .force_stb (frc),
         .force_act (tmr_act_e'(wr_data[CB_ACT0 + 2*i +: 2])),
         .cmp_now   (cmp_now[i]),
         .match_ev  (m_ev[i]),
         .wave      (waves[i])
      );
   end

   tmr16_capture #(.W(CNT_W), .SYNC(SYNC), .NC_DEPTH(NC_DEPTH)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (cap_in),
      .rise_sel (rise_q),
      .nc_en    (nc_q),
      .cnt      (cnt_q),
      .cap_val  (cap_value),
      .cap_ev   (cap_ev)
   );

   assign set_v = {cap_ev, m_ev[1], m_ev[0], ovf_ev};
   assign clr_v = wr_flags ? wr_data[NUM_FLAGS-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (flags_q & ~clr_v) | set_v;
   end

   assign wave_a    = waves[0];
   assign wave_b    = waves[1];
   assign irq_flags = flags_q;
endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk #(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [CNT_W-1:0]  wr_data,
   input logic              wave_a,
   input logic [CNT_W-1:0]  cap_value,
   input logic [3:0]        irq_flags,
   input logic [CNT_W-1:0]  cnt,
   input logic              up,
   input logic [1:0]        mode,
   input logic              match_a
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   logic [3:0] clr_m;
   assign clr_m = (wr_en && wr_addr == ADDR_W'(4)) ? wr_data[3:0] : 4'h0;

   a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt));

   a_r2_wrap_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mode == 2'd0 && cnt == '1) |=> (cnt == '0 && irq_flags[0]));

   a_r3_ctc_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mode == 2'd1 && match_a) |=> (cnt == '0));

   a_r5_pc_down_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mode[1] && !up && cnt != '0) |=> (cnt == $past(cnt) - ONE));

   a_r8_force_ignored_pc: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == '0 && wr_data[1] && wr_data[8] && !match_a) |=> $stable(wave_a));

   a_r9_capture_flags: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cap_value) |-> irq_flags[3]);

   a_r11_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((irq_flags & $past(irq_flags & ~clr_m)) == $past(irq_flags & ~clr_m)));
endmodule

bind tmr16_core tmr16_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .wave_a    (wave_a),
   .cap_value (cap_value),
   .irq_flags (irq_flags),
   .cnt       (cnt_q),
   .up        (cnt_up),
   .mode      (mode_q),
   .match_a   (m_ev[0])
);

// File: tb/sim_tmr16_core.sv
module sim_tmr16_core;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        tick;
   logic        wr_en;
   logic [2:0]  wr_addr;
   logic [15:0] wr_data;
   logic        cap_in;
   logic        wave_a;
   logic        wave_b;
   logic [15:0] cap_value;
   logic [3:0]  irq_flags;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   tmr16_core u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .cap_in    (cap_in),
      .wave_a    (wave_a),
      .wave_b    (wave_b),
      .cap_value (cap_value),
      .irq_flags (irq_flags)
   );

   // force-strobe vectors: {action code, expected wave_a after the strobe}
   localparam logic [2:0] FRC_TAB [7] = '{
      {2'd3, 1'b1}, {2'd1, 1'b0}, {2'd1, 1'b1}, {2'd0, 1'b1},
      {2'd2, 1'b0}, {2'd1, 1'b1}, {2'd2, 1'b0}
   };

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; cap_in = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic logic pin_of(input bit sel_b);
      return sel_b ? wave_b : wave_a;
   endfunction

   task automatic wait_level(input bit sel_b, input logic lvl, output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (pin_of(sel_b) !== lvl && n < 400);
   endtask

   task automatic wait_change(input bit sel_b, output int n);
      logic v;
      v = pin_of(sel_b);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (pin_of(sel_b) === v && n < 400);
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int n;
      do_reset();
      // R1 reset state
      chk("R1 wave_a", wave_a, 0);
      chk("R1 wave_b", wave_b, 0);
      chk("R1 cap_value", cap_value, 0);
      chk("R1 irq_flags", irq_flags, 0);

      // R4 / R8: forced actions from the vector table, free-running mode, no tick
      for (int i = 0; i < 7; i++) begin
         wr(3'd0, 16'h0100 | (16'(FRC_TAB[i][2:1]) << 2));
         chk("R4 forced action on wave_a", wave_a, FRC_TAB[i][0]);
         chk("R8 force leaves match flag clear", irq_flags[1], 0);
      end

      // R8: strobe ignored when written mode is phase-correct
      do_reset();
      wr(3'd0, 16'h010E);
      chk("R8 force ignored in PWM", wave_a, 0);

      // R3 / R4: clear-on-match with toggling outputs
      do_reset();
      wr(3'd1, 16'd5);
      wr(3'd2, 16'd3);
      wr(3'd0, 16'h0015);
      @(negedge clk); tick = 1'b1;
      wait_change(0, n);
      wait_change(0, n);
      chk("R3 ctc period on wave_a", n, 6);
      wait_change(1, n);
      wait_change(1, n);
      chk("R4 toggle period on wave_b", n, 6);
      chk("R3 match flags", irq_flags[2:1], 2'b11);
      chk("R2 no overflow in short ctc", irq_flags[0], 0);

      // R5 / R6 / R7: phase-correct PWM, top 4, A non-inverting 2, B inverting 2
      do_reset();
      wr(3'd3, 16'd4);
      wr(3'd1, 16'd2);
      wr(3'd2, 16'd2);
      wr(3'd0, 16'h003A);
      @(negedge clk); tick = 1'b1;
      wait_level(0, 1, n);
      wait_level(0, 0, n);
      chk("R6 high ticks cmp2", n, 4);
      wait_level(0, 1, n);
      chk("R6 low ticks cmp2", n, 4);
      chk("R6 inverting wave_b", wave_b, 0);
      chk("R5 overflow at bottom", irq_flags[0], 1);
      wr(3'd1, 16'd1);
      wait_level(0, 0, n);
      wait_level(0, 1, n);
      chk("R7 first low after buffered write", n, 5);
      wait_level(0, 0, n);
      chk("R7 high ticks cmp1", n, 2);
      wait_level(0, 1, n);
      chk("R6 low ticks cmp1", n, 6);

      // R9 / R10 / R2: capture with frozen counter
      do_reset();
      wr(3'd0, 16'h0040);
      @(negedge clk); tick = 1'b1;
      repeat (10) @(negedge clk);
      tick = 1'b0;
      cap_in = 1'b1;
      repeat (8) @(negedge clk);
      chk("R9 R2 captured count", cap_value, 10);
      chk("R9 capture flag", irq_flags[3], 1);
      wr(3'd4, 16'h0008);
      chk("R11 flag cleared", irq_flags[3], 0);
      cap_in = 1'b0;
      repeat (8) @(negedge clk);
      chk("R9 other edge ignored", irq_flags[3], 0);
      wr(3'd0, 16'h00C0);
      tick = 1'b1;
      repeat (5) @(negedge clk);
      tick = 1'b0;
      cap_in = 1'b1;
      repeat (2) @(negedge clk);
      cap_in = 1'b0;
      repeat (10) @(negedge clk);
      chk("R10 short pulse rejected flag", irq_flags[3], 0);
      chk("R10 short pulse rejected value", cap_value, 10);
      cap_in = 1'b1;
      repeat (10) @(negedge clk);
      chk("R10 long pulse accepted", irq_flags[3], 1);
      chk("R10 new captured count", cap_value, 15);

      // R2 / R11: free-running wrap
      do_reset();
      tick = 1'b1;
      repeat (65535) @(negedge clk);
      chk("R2 no overflow before wrap", irq_flags[0], 0);
      @(negedge clk);
      chk("R2 overflow at wrap", irq_flags[0], 1);
      wr(3'd4, 16'h0001);
      chk("R11 overflow cleared", irq_flags[0], 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule